// File: doc/BRIEF.md
# Always-On Reset and Stall Controller

This block sits in the always-on domain and turns register writes into the reset, stall and boot-selection controls of a main processor domain and its peripherals. Software writes a small set of control words through a plain write strobe and reads them back through a combinational read port. Reset requests are write-trigger bits that leave the block as pulses of a guaranteed minimum width. The core stall level asserts only while a specific 8-bit key sits in its field.

The system reset pulse reaches two peripheral outputs, one for the I/O multiplexer and one for the USB block. Each can be exempted through its own bypass bit. A download-boot request bit is exported as a level. Its value is latched into a read-only status bit when the system reset pulse ends. The block holds its state across the software system reset, and only the power-on reset `rst_n` returns it to defaults.

The register port is control traffic, not a stream. A write completes in the cycle its strobe is high, so there is no back-pressure and no handshake.

Top module: `aon_rst_ctrl`

## Requirements
- R1: After power-on reset every output is 0 except `boot_rom_sel_o`, which is 1. Reading word 1 returns 0x200, and words 0 and 2 read 0.
- R2: `core_stall_o` is 1 exactly while bits [7:0] of word 1 hold the key value STALL_KEY (default 0x86). Any other value gives 0.
- R3: Writing word 0 with bit 0 = 1 drives `sys_rst_o` high for exactly PULSE_W cycles, starting in the cycle after the write. Writing bit 0 = 0 produces no pulse, and bit 0 always reads 0.
- R4: Writing word 1 with bit 8 = 1 drives `core_rst_o` high for exactly PULSE_W cycles in the same way. Bit 8 reads 0, and the write also updates the other fields of word 1.
- R5: Bit 9 of word 1 drives `boot_rom_sel_o` (1 = ROM boot address, 0 = low-power memory). Its reset value is 1.
- R6: `iomux_rst_o` follows `sys_rst_o` while bit 0 of word 2 is 0, and it stays 0 while that bit is 1.
- R7: `usb_rst_o` follows `sys_rst_o` while bit 1 of word 2 is 0, and it stays 0 while that bit is 1.
- R8: Bit 1 of word 0 drives `dl_boot_req_o`. One cycle after `sys_rst_o` falls, the value of that bit is copied into the status, which is visible on `dl_boot_stat_o` and at bit 2 of word 0. Writes to bit 2 are ignored. Only `rst_n` clears the status.
- R9: Bit 10 of word 1 drives `core_dbg_rst_bypass_o` (1 = debug reset of the core bypassed).
- R10: A software system reset pulse leaves every control field of words 0 to 2 unchanged.
- R11: A new request during an active pulse restarts the count, so the output stays high for PULSE_W cycles after the last request.
- R12: A write to an address other than 0, 1 or 2 changes nothing and produces no pulse. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Combinational read data |
| sys_rst_o | output | 1 | Stretched system reset pulse |
| core_rst_o | output | 1 | Stretched core reset pulse |
| iomux_rst_o | output | 1 | System reset as seen by the I/O multiplexer |
| usb_rst_o | output | 1 | System reset as seen by the USB block |
| core_stall_o | output | 1 | Core stall level |
| boot_rom_sel_o | output | 1 | Boot vector select, 1 = ROM |
| dl_boot_req_o | output | 1 | Forced download-boot request |
| dl_boot_stat_o | output | 1 | Latched download-boot status |
| core_dbg_rst_bypass_o | output | 1 | Core debug reset bypass enable |

## Verification
The bench builds the block with PULSE_W = 3 and the default key 0x86. A short pulse lets every pulse be counted cycle by cycle inside a small sampling window. It also lets a retrigger be placed in the middle of a pulse, and it makes the one-cycle delay between the end of a pulse and the status capture easy to observe. With a 2-bit address, one unmapped address is left over and used for the ignored-write case.

// File: rtl/aon_rst_pkg.sv
package aon_rst_pkg;
  // word addresses
  localparam int ADDR_SYS  = 0;
  localparam int ADDR_CORE = 1;
  localparam int ADDR_BYP  = 2;
  // word 0 fields
  localparam int SYS_TRIG_BIT   = 0;
  localparam int SYS_DLREQ_BIT  = 1;
  localparam int SYS_DLSTAT_BIT = 2;
  // word 1 fields
  localparam int CORE_KEY_LSB  = 0;
  localparam int CORE_KEY_W    = 8;
  localparam int CORE_TRIG_BIT = 8;
  localparam int CORE_BOOT_BIT = 9;
  localparam int CORE_DBG_BIT  = 10;
  // word 2 fields
  localparam int BYP_IO_BIT  = 0;
  localparam int BYP_USB_BIT = 1;
  // pulse channels
  localparam int N_PULSE = 2;
  localparam int CH_SYS  = 0;
  localparam int CH_CORE = 1;

  typedef struct packed {
    logic [CORE_KEY_W-1:0] key;
    logic                  boot_rom;
    logic                  dbg_byp;
    logic                  dl_req;
    logic                  io_byp;
    logic                  usb_byp;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{key: '0, boot_rom: 1'b1, dbg_byp: 1'b0,
                                   dl_req: 1'b0, io_byp: 1'b0, usb_byp: 1'b0};
endpackage

// File: rtl/aon_rst_regs.sv
module aon_rst_regs
  import aon_rst_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 32,
  parameter logic [CORE_KEY_W-1:0] STALL_KEY = 8'h86
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  input  logic                 dl_stat_i,
  output logic [N_PULSE-1:0]   trig_o,
  output ctrl_t                ctrl_o,
  output logic                 core_stall_o
);
  ctrl_t ctrl_q;
  logic  wr_sys, wr_core, wr_byp;
  logic  unused_wdata;

  assign wr_sys  = wr_en && (wr_addr == AW'(ADDR_SYS));
  assign wr_core = wr_en && (wr_addr == AW'(ADDR_CORE));
  assign wr_byp  = wr_en && (wr_addr == AW'(ADDR_BYP));
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else begin
      if (wr_sys) ctrl_q.dl_req <= wr_data[SYS_DLREQ_BIT];
      if (wr_core) begin
        ctrl_q.key      <= wr_data[CORE_KEY_LSB +: CORE_KEY_W];
        ctrl_q.boot_rom <= wr_data[CORE_BOOT_BIT];
        ctrl_q.dbg_byp  <= wr_data[CORE_DBG_BIT];
      end
      if (wr_byp) begin
        ctrl_q.io_byp  <= wr_data[BYP_IO_BIT];
        ctrl_q.usb_byp <= wr_data[BYP_USB_BIT];
      end
    end
  end

  // write-trigger requests: one cycle wide, never stored
  assign trig_o[CH_SYS]  = wr_sys  && wr_data[SYS_TRIG_BIT];
  assign trig_o[CH_CORE] = wr_core && wr_data[CORE_TRIG_BIT];

  assign ctrl_o       = ctrl_q;
  assign core_stall_o = (ctrl_q.key == STALL_KEY);

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_SYS)) begin
      rd_data[SYS_DLREQ_BIT]  = ctrl_q.dl_req;
      rd_data[SYS_DLSTAT_BIT] = dl_stat_i;
    end else if (rd_addr == AW'(ADDR_CORE)) begin
      rd_data[CORE_KEY_LSB +: CORE_KEY_W] = ctrl_q.key;
      rd_data[CORE_BOOT_BIT] = ctrl_q.boot_rom;
      rd_data[CORE_DBG_BIT]  = ctrl_q.dbg_byp;
    end else if (rd_addr == AW'(ADDR_BYP)) begin
      rd_data[BYP_IO_BIT]  = ctrl_q.io_byp;
      rd_data[BYP_USB_BIT] = ctrl_q.usb_byp;
    end
  end

  // R2: the stall level only moves after a write cycle
  assert_stall_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(core_stall_o));
  // R3: trigger bits never read back as 1
  assert_trig_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(ADDR_SYS)) |-> !rd_data[SYS_TRIG_BIT]);
  // R12: writes outside the map leave the control fields alone
  assert_unmapped_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sys && !wr_core && !wr_byp) |=> $stable(ctrl_q));
endmodule

// File: rtl/aon_pulse_stretch.sv
module aon_pulse_stretch #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (trig_i)       cnt_q <= CW'(PULSE_W);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  // run-length monitor for the minimum-width check
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (!pulse_o)                   run_q <= '0;
    else if (run_q != (CW+1)'(PULSE_W))  run_q <= run_q + 1'b1;
  end

  // R3/R4: a pulse never ends before PULSE_W cycles
  assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (run_q == (CW+1)'(PULSE_W)));
  // R11: every request is followed by an active output
  assert_trig_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o);
endmodule

// File: rtl/aon_rst_fanout.sv
module aon_rst_fanout (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_i,
  input  logic io_byp_i,
  input  logic usb_byp_i,
  input  logic dl_req_i,
  output logic io_rst_o,
  output logic usb_rst_o,
  output logic dl_stat_o
);
  logic sys_d_q;
  logic stat_q;

  assign io_rst_o  = sys_rst_i && !io_byp_i;
  assign usb_rst_o = sys_rst_i && !usb_byp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_d_q <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      sys_d_q <= sys_rst_i;
      if (sys_d_q && !sys_rst_i) stat_q <= dl_req_i;
    end
  end

  assign dl_stat_o = stat_q;

  // R6: a bypassed I/O multiplexer never sees the reset
  assert_io_shield_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_byp_i |-> !io_rst_o);
  // R7: an unbypassed USB block sees every system reset
  assert_usb_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && !usb_byp_i) |-> usb_rst_o);
  // R8: status moves only right after the end of a system reset
  assert_stat_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sys_rst_i) |=> $stable(dl_stat_o));
endmodule

// File: rtl/aon_rst_ctrl.sv
module aon_rst_ctrl
  import aon_rst_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 32,
  parameter int PULSE_W = 4,
  parameter logic [7:0] STALL_KEY = 8'h86
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sys_rst_o,
  output logic          core_rst_o,
  output logic          iomux_rst_o,
  output logic          usb_rst_o,
  output logic          core_stall_o,
  output logic          boot_rom_sel_o,
  output logic          dl_boot_req_o,
  output logic          dl_boot_stat_o,
  output logic          core_dbg_rst_bypass_o
);
  logic [N_PULSE-1:0] trig;
  logic [N_PULSE-1:0] pulse;
  ctrl_t              ctrl;
  logic               dl_stat;

  aon_rst_regs #(.AW(AW), .DW(DW), .STALL_KEY(STALL_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dl_stat_i(dl_stat), .trig_o(trig), .ctrl_o(ctrl),
    .core_stall_o(core_stall_o)
  );

  for (genvar g = 0; g < N_PULSE; g++) begin : g_stretch
    aon_pulse_stretch #(.PULSE_W(PULSE_W)) u_stretch (
      .clk(clk), .rst_n(rst_n), .trig_i(trig[g]), .pulse_o(pulse[g])
    );
  end

  aon_rst_fanout u_fanout (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(pulse[CH_SYS]),
    .io_byp_i(ctrl.io_byp), .usb_byp_i(ctrl.usb_byp), .dl_req_i(ctrl.dl_req),
    .io_rst_o(iomux_rst_o), .usb_rst_o(usb_rst_o), .dl_stat_o(dl_stat)
  );

  assign sys_rst_o             = pulse[CH_SYS];
  assign core_rst_o            = pulse[CH_CORE];
  assign boot_rom_sel_o        = ctrl.boot_rom;
  assign dl_boot_req_o         = ctrl.dl_req;
  assign dl_boot_stat_o        = dl_stat;
  assign core_dbg_rst_bypass_o = ctrl.dbg_byp;

  // R3: a system reset request shows on the pin in the next cycle
  assert_sys_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_SYS) && wr_data[SYS_TRIG_BIT]) |=> sys_rst_o);
  // R4: a core reset request shows on the pin in the next cycle
  assert_core_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_CORE) && wr_data[CORE_TRIG_BIT]) |=> core_rst_o);
  // R10: the system reset pulse leaves the boot selection alone
  assert_keep_boot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && !wr_en) |=> $stable(boot_rom_sel_o));
endmodule

// File: tb/test_aon_rst_ctrl.sv
module test_aon_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;
  localparam int DW = 32;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic sys_rst_o, core_rst_o, iomux_rst_o, usb_rst_o, core_stall_o;
  logic boot_rom_sel_o, dl_boot_req_o, dl_boot_stat_o, core_dbg_rst_bypass_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  aon_rst_ctrl #(.AW(AW), .DW(DW), .PULSE_W(PW), .STALL_KEY(8'h86)) i_aon_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_rst_o(sys_rst_o), .core_rst_o(core_rst_o), .iomux_rst_o(iomux_rst_o),
    .usb_rst_o(usb_rst_o), .core_stall_o(core_stall_o),
    .boot_rom_sel_o(boot_rom_sel_o), .dl_boot_req_o(dl_boot_req_o),
    .dl_boot_stat_o(dl_boot_stat_o), .core_dbg_rst_bypass_o(core_dbg_rst_bypass_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // word-1 vectors: {write data, stall, boot, dbg}
  typedef struct packed { logic [11:0] d; logic st; logic bt; logic dg; } vec_t;
  localparam vec_t VECS [8] = '{
    '{12'h086, 1'b1, 1'b0, 1'b0},
    '{12'h085, 1'b0, 1'b0, 1'b0},
    '{12'h286, 1'b1, 1'b1, 1'b0},
    '{12'h087, 1'b0, 1'b0, 1'b0},
    '{12'h486, 1'b1, 1'b0, 1'b1},
    '{12'h606, 1'b0, 1'b1, 1'b1},
    '{12'h0C6, 1'b0, 1'b0, 1'b0},
    '{12'h000, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // sample one output at n negedges starting now; 0 sys,1 core,2 io,3 usb
  task automatic count_high(input int sel, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      case (sel)
        0: c += int'(sys_rst_o);
        1: c += int'(core_rst_o);
        2: c += int'(iomux_rst_o);
        default: c += int'(usb_rst_o);
      endcase
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R5 boot default
    chk("R1 outputs", {sys_rst_o, core_rst_o, iomux_rst_o, usb_rst_o, core_stall_o,
                       dl_boot_req_o, dl_boot_stat_o, core_dbg_rst_bypass_o}, 0);
    chk("R5 boot default", boot_rom_sel_o, 1);
    rd(1, r); chk("R1 word1", r, 32'h200);
    rd(0, r); chk("R1 word0", r, 0);
    rd(2, r); chk("R1 word2", r, 0);

    // R2 R5 R9 vector walk
    foreach (VECS[i]) begin
      wr(1, {20'h0, VECS[i].d});
      chk("R2 stall", core_stall_o, VECS[i].st);
      chk("R5 boot", boot_rom_sel_o, VECS[i].bt);
      chk("R9 dbg", core_dbg_rst_bypass_o, VECS[i].dg);
      rd(1, r); chk("R2 readback", r, {20'h0, VECS[i].d});
      chk("R4 no pulse", core_rst_o, 0);
    end

    // R3 system reset pulse, R6/R7 follow when not bypassed
    wr(0, 32'h1);
    rd(0, r); chk("R3 trig reads 0", r[0], 0);
    chk("R6 io follows", iomux_rst_o, 1);
    chk("R7 usb follows", usb_rst_o, 1);
    count_high(0, 6, c); chk("R3 width", c, PW);
    wr(0, 32'h0);
    count_high(0, 4, c); chk("R3 zero ignored", c, 0);

    // R4 core reset pulse, word-1 fields updated together
    wr(1, 32'h186);
    chk("R4 stall set with trig", core_stall_o, 1);
    rd(1, r); chk("R4 trig reads 0", r, 32'h086);
    count_high(1, 6, c); chk("R4 width", c, PW);
    chk("R4 sys quiet", sys_rst_o, 0);

    // R6 io bypass
    wr(2, 32'h1);
    wr(0, 32'h1);
    count_high(2, 6, c); chk("R6 io shielded", c, 0);
    wr(0, 32'h1);
    count_high(3, 6, c); chk("R7 usb follows", c, PW);
    // R7 usb bypass
    wr(2, 32'h2);
    wr(0, 32'h1);
    count_high(3, 6, c); chk("R7 usb shielded", c, 0);
    wr(0, 32'h1);
    count_high(2, 6, c); chk("R6 io follows", c, PW);
    wr(2, 32'h0);

    // R8 download request and captured status
    wr(0, 32'h2);
    chk("R8 req", dl_boot_req_o, 1);
    chk("R8 stat before", dl_boot_stat_o, 0);
    wr(0, 32'h3);
    count_high(0, 6, c);
    chk("R8 stat captured", dl_boot_stat_o, 1);
    rd(0, r); chk("R8 word0", r, 32'h6);
    wr(0, 32'h0);
    chk("R8 req cleared", dl_boot_req_o, 0);
    rd(0, r); chk("R8 stat kept on write", r, 32'h4);
    wr(0, 32'h4);
    rd(0, r); chk("R8 stat bit write ignored", r, 32'h4);
    wr(0, 32'h1);
    count_high(0, 6, c);
    chk("R8 stat recaptured 0", dl_boot_stat_o, 0);

    // R10 software reset keeps state
    wr(1, 32'h486);
    wr(2, 32'h3);
    wr(0, 32'h3);
    count_high(0, 6, c);
    rd(1, r); chk("R10 word1 kept", r, 32'h486);
    rd(2, r); chk("R10 word2 kept", r, 32'h3);
    chk("R10 req kept", dl_boot_req_o, 1);
    wr(2, 32'h0);

    // R11 retrigger inside a pulse: 1 sample, then full width again
    wr(0, 32'h1);
    chk("R11 first high", sys_rst_o, 1);
    wr(0, 32'h1);
    count_high(0, 8, c); chk("R11 restart width", c, PW);

    // R12 unmapped address
    wr(3, 32'hFFFF_FFFF);
    chk("R12 no sys pulse", sys_rst_o, 0);
    chk("R12 no core pulse", core_rst_o, 0);
    chk("R12 stall unchanged", core_stall_o, 1);
    rd(3, r); chk("R12 reads 0", r, 0);
    rd(1, r); chk("R12 word1 unchanged", r, 32'h486);

    // R1/R8 power-on reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 stat cleared by por", dl_boot_stat_o, 0);
    chk("R1 stall cleared", core_stall_o, 0);
    chk("R1 boot restored", boot_rom_sel_o, 1);
    rd(1, r); chk("R1 word1 after por", r, 32'h200);

    finish_run();
  end
endmodule